// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

The block gathers a small set of level-sensitive interrupt request lines into one active-low request for a host processor input pin. Each line feeds a sticky pending flag. A flag goes to 1 on any clock edge where its line is high, and it stays at 1 until software clears it. A separate enable register qualifies each flag. The output is low whenever any flag is pending with its enable bit set.

Software reaches two registers through a synchronous strobe interface. The pending register clears a flag when a 0 is written to that bit position. Writing 1 to a bit leaves it as it is, so software can clear selected sources by writing back the value it read with only those bits zeroed. The enable register is read and written as plain storage.

The output cannot pulse while another enabled source stays pending. A host that waits for an edge must therefore keep re-reading the pending register until the pending value with the enables applied reads as zero.

Top module: `irq_sticky_agg`

## Requirements
- R1: After reset is released, all pending flags and all enable bits are 0, `irq_n_o` is 1 and `rdata_o` is 0.
- R2: On any clock edge where a source line is high, its pending flag reads 1 after that edge.
- R3: On a clock edge where a source line is low and no clear hits its flag, the flag keeps its previous value.
- R4: A write to the pending register (address 0) clears each flag whose `wdata_i` bit (bit i for source i) is 0. A flag whose `wdata_i` bit is 1 is left unchanged.
- R5: If a clear and a high source line meet on the same edge, the flag is set. A line that is still high re-sets its flag on the first edge after a clear.
- R6: A write to the enable register (address 1) loads `wdata_i` bits [NUM_SRC-1:0] into the enable bits, which then hold that value until the next such write.
- R7: `irq_n_o` is 0 exactly when at least one source has both its pending flag and its enable bit at 1. Otherwise it is 1.
- R8: A read strobe returns the selected register in `rdata_o` bits [NUM_SRC-1:0] on the cycle after the strobe, with every higher bit 0. A read sees the state from before any write in the same cycle, and `rdata_o` holds its value between strobes.
- R9: Writes to addresses other than 0 and 1 change no state, and reads of those addresses return 0.
- R10: While any enabled flag stays pending, `irq_n_o` stays low with no rising transition, even when further sources become pending or some sources are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | NUM_SRC | Level-sensitive interrupt request lines, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register word address (0 pending, 1 enable) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after `rd_en_i` |
| irq_n_o | output | 1 | Combined interrupt request, active low |

## Verification
The bench builds the block with its defaults: three sources, a two-bit address and a 32-bit data path. With a two-bit address, addresses 2 and 3 are unmapped, so writes and reads to them can be checked for R9. The 32-bit data path leaves 29 upper bits that must read as zero, even after an all-ones write to the enable register. Directed sequences cover set-beats-clear, re-set of a held line, write-one-keeps, and a second source arriving while the output is already low. A stretch of pseudo-random traffic then mixes all of these against the reference model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == STATUS_ADDR)      sel_o = SEL_STATUS;
    else if (addr_i == ENABLE_ADDR) sel_o = SEL_ENABLE;
    else                            sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic clr_i,
  output logic q_o
);
  // a high line wins over a clear so no request is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (irq_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> q_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && !clr_i) |=> (q_o == $past(q_o)));
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !irq_i) |=> !q_o);
endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_n_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr;
  logic               wr_status;
  logic [DATA_W-1:0]  rd_val;

  irq_agg_decode #(
    .ADDR_W     (ADDR_W),
    .STATUS_ADDR(STATUS_ADDR),
    .ENABLE_ADDR(ENABLE_ADDR)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign wr_status = wr_en_i && (sel == SEL_STATUS);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign clr[i] = wr_status && !wdata_i[i];
    irq_status_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .irq_i (irq_src_i[i]),
      .clr_i (clr[i]),
      .q_o   (status_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             en_q <= '0;
    else if (wr_en_i && sel == SEL_ENABLE)   en_q <= wdata_i[NUM_SRC-1:0];
  end

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_STATUS: rd_val[NUM_SRC-1:0] = status_q;
      SEL_ENABLE: rd_val[NUM_SRC-1:0] = en_q;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign irq_n_o = ~|(status_q & en_q);

  if (PAD_W > 0) begin : g_pad
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

    p_rd_upper_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i |=> (rdata_o[DATA_W-1:NUM_SRC] == '0));
  end

  p_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_ENABLE) |=> (en_q == $past(wdata_i[NUM_SRC-1:0])));
  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE) |=> $stable(en_q));
  p_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/irq_sticky_agg_test.sv
`timescale 1ns/1ps
module irq_sticky_agg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  irq_src_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_n_o;

  int checks = 0;
  int errors = 0;
  int rises  = 0;
  bit done   = 0;

  // reference state
  logic [2:0]  m_st = '0;
  logic [2:0]  m_en = '0;
  logic [31:0] m_rd = '0;
  logic        prev_irq = 1'b1;

  irq_sticky_agg uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_n_o(irq_n_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] irq, input logic we, input logic re,
                     input logic [1:0] a, input logic [31:0] wd, input string tag);
    logic exp_irq;
    irq_src_i = irq; wr_en_i = we; rd_en_i = re; addr_i = a; wdata_i = wd;
    @(posedge clk_i);
    if (re) m_rd = (a == 2'd0) ? {29'd0, m_st} : (a == 2'd1) ? {29'd0, m_en} : 32'd0;
    if (we && a == 2'd0) m_st = irq | (m_st & wd[2:0]);
    else                 m_st = irq | m_st;
    if (we && a == 2'd1) m_en = wd[2:0];
    @(negedge clk_i);
    exp_irq = ~|(m_st & m_en);
    check(irq_n_o === exp_irq, {tag, "/R7 irq_n_o"}, {31'd0, irq_n_o}, {31'd0, exp_irq});
    check(rdata_o === m_rd, {tag, "/R8 rdata_o"}, rdata_o, m_rd);
    if (!prev_irq && irq_n_o) rises++;
    prev_irq = irq_n_o;
    wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic idle(input logic [2:0] irq, input string tag);
    cyc(irq, 1'b0, 1'b0, 2'd0, 32'd0, tag);
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cyc(irq_src_i, 1'b0, 1'b1, a, 32'd0, tag);
    check(rdata_o === exp, {tag, " readback"}, rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(irq_n_o === 1'b1, "R1 irq_n_o", {31'd0, irq_n_o}, 32'd1);
    check(rdata_o === 32'd0, "R1 rdata_o", rdata_o, 32'd0);
    rd_expect(2'd0, 32'd0, "R1 status");
    rd_expect(2'd1, 32'd0, "R1 enable");

    // R6 enable programming, upper bits dropped (R8)
    cyc(3'b000, 1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF, "R6");
    rd_expect(2'd1, 32'd7, "R8 upper-zero");
    cyc(3'b000, 1'b1, 1'b0, 2'd1, 32'd5, "R6");
    rd_expect(2'd1, 32'd5, "R6 enable");

    // R2/R3 one-cycle pulse sticks
    idle(3'b001, "R2");
    idle(3'b000, "R3");
    idle(3'b000, "R3");
    rd_expect(2'd0, 32'd1, "R3 sticky");
    check(irq_n_o === 1'b0, "R7 asserted", {31'd0, irq_n_o}, 32'd0);

    // R4 write-one keeps, write-zero clears
    cyc(3'b000, 1'b1, 1'b0, 2'd0, 32'd7, "R4");
    rd_expect(2'd0, 32'd1, "R4 keep");
    cyc(3'b000, 1'b1, 1'b0, 2'd0, 32'd6, "R4");
    rd_expect(2'd0, 32'd0, "R4 clear");
    check(irq_n_o === 1'b1, "R4 released", {31'd0, irq_n_o}, 32'd1);

    // R5 clear coincident with high line, then re-set while held
    cyc(3'b100, 1'b0, 1'b0, 2'd0, 32'd0, "R5");
    cyc(3'b100, 1'b1, 1'b0, 2'd0, 32'd0, "R5");
    rd_expect(2'd0, 32'd4, "R5 set wins");
    cyc(3'b000, 1'b1, 1'b0, 2'd0, 32'd0, "R5");
    rd_expect(2'd0, 32'd0, "R5 cleared once low");

    // R7 masked source does not assert output
    idle(3'b010, "R7");
    idle(3'b000, "R7");
    check(irq_n_o === 1'b1, "R7 masked", {31'd0, irq_n_o}, 32'd1);
    rd_expect(2'd0, 32'd2, "R7 pending masked");
    cyc(3'b000, 1'b1, 1'b0, 2'd0, 32'd0, "R7");

    // R10 no rising edge while any enabled source pending
    cyc(3'b000, 1'b1, 1'b0, 2'd1, 32'd7, "R10");
    idle(3'b001, "R10");
    rises = 0;
    idle(3'b010, "R10");
    cyc(3'b000, 1'b1, 1'b0, 2'd0, 32'd6, "R10");
    idle(3'b100, "R10");
    cyc(3'b000, 1'b1, 1'b0, 2'd0, 32'd4, "R10");
    check(rises == 0, "R10 no rise", rises, 0);
    check(irq_n_o === 1'b0, "R10 still low", {31'd0, irq_n_o}, 32'd0);
    cyc(3'b000, 1'b1, 1'b0, 2'd0, 32'd0, "R10");
    check(irq_n_o === 1'b1, "R10 released", {31'd0, irq_n_o}, 32'd1);

    // R9 unmapped addresses
    idle(3'b011, "R9");
    cyc(3'b000, 1'b1, 1'b0, 2'd2, 32'd0, "R9");
    cyc(3'b000, 1'b1, 1'b0, 2'd3, 32'd0, "R9");
    rd_expect(2'd2, 32'd0, "R9 read2");
    rd_expect(2'd3, 32'd0, "R9 read3");
    rd_expect(2'd0, 32'd3, "R9 status kept");
    rd_expect(2'd1, 32'd7, "R9 enable kept");

    // R8 read sees pre-write value in same cycle
    cyc(3'b000, 1'b1, 1'b1, 2'd0, 32'd0, "R8");
    check(rdata_o === 32'd3, "R8 read-before-write", rdata_o, 32'd3);
    rd_expect(2'd0, 32'd0, "R8 after write");

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc((lfsr[2:0] & {3{lfsr[9]}}), lfsr[3] & lfsr[4], lfsr[5],
          lfsr[7:6], {24'd0, lfsr[15:8]}, "R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule